// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a NOR-style flash after software or another engine has issued a program or erase command. Once started, it keeps reading the flash over a simple read request/acknowledge port and interprets three status bits in each returned word: a toggle bit (bit 6), a failure bit (bit 5) and a data-polling bit (bit 7). It ends every accepted start with exactly one single-cycle pulse, either `done_o` for success or `err_o` for failure.

Two detection methods are selected at start. With the toggle method the first read only captures bit 6, and each following read is compared against the previous one. Equal values mean the internal engine has stopped. With the data-polling method every read is tested on its own: bit 7 must equal the expected bit for a program, or read 1 for an erase. When bit 5 shows up on a read that did not already show completion, the controller takes two confirming reads. If bit 6 agrees on both, the operation finished just as the failure bit was seen, and the result is success. Otherwise it writes the reset command and reports an error. A poll limit ends a run that never resolves. The limit leads to the same reset write and error pulse.

The states are IDLE, SEED (first toggle-method read), POLL, CHK_A and CHK_B (the confirming pair), RESET (reset command write), OK and FAIL. The transitions are:
- IDLE→SEED on a start with the toggle method.
- IDLE→POLL on a start with data polling.
- SEED→POLL on the acknowledge.
- POLL→OK on completion.
- POLL→CHK_A when bit 5 is set.
- POLL→RESET when the poll limit is reached.
- POLL→POLL otherwise.
- CHK_A→CHK_B on the acknowledge.
- CHK_B→OK when the two bit 6 values agree, and CHK_B→RESET when they differ.
- RESET→FAIL on the write acknowledge.
- OK→IDLE and FAIL→IDLE unconditionally.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `rd_req_o`, `wr_req_o`, `done_o` and `err_o` are all low.
- R2: Toggle method (`use_dpoll_i`=0): the first read only captures bit 6, and its bit 5 is not examined. A later read whose bit 6 equals that of the previous read ends the run with a `done_o` pulse, and no further read is issued.
- R3: Data polling for a program (`use_dpoll_i`=1, `erase_i`=0): a read whose bit 7 equals `exp_bit_i` (captured at start) ends the run with `done_o`.
- R4: Data polling for an erase (`erase_i`=1): a read with bit 7 = 1 ends the run with `done_o`, and `exp_bit_i` has no effect.
- R5: A poll read that does not show completion but has bit 5 = 1 is followed by exactly two confirming reads. If their bit 6 values are equal, the run ends with `done_o` and no write.
- R6: If the two confirming reads differ in bit 6, the controller raises `wr_req_o` with `wr_data_o` = `RST_CMD` (default 0xF0) and holds it until `wr_ack_i`. It then pulses `err_o`.
- R7: If `MAX_POLLS` poll reads pass without completion or bit 5, the run ends with the reset write and `err_o`. The confirming reads are not counted toward this limit.
- R8: `done_o` and `err_o` are single-cycle, never high together, and exactly one of them pulses per accepted start.
- R9: A `start_i` pulse while a run is active is ignored. The read count and the outcome are unchanged.
- R10: `rd_req_o` stays high until `rd_ack_i`. Each acknowledge cycle completes one read, whose data is taken from `rd_data_i` in that cycle. Read and write requests are never high together.
- R11: An aborted operation that toggles only briefly and then reads stable, without bit 5, ends with `done_o` and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| use_dpoll_i | input | 1 | 1 selects data polling, 0 selects the toggle method |
| erase_i | input | 1 | 1 for an erase, 0 for a program |
| exp_bit_i | input | 1 | Expected bit 7 value for a program |
| rd_req_o | output | 1 | Read request |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Word returned by the flash |
| wr_req_o | output | 1 | Write request for the reset command |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | DW | Reset command word |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse (engine fault or poll limit) |

## Verification
The assertions assume that the flash side acknowledges only while the matching request is high and never acknowledges in two consecutive cycles. The bench's responder raises each acknowledge for one cycle, and only after seeing the request at a falling edge, with zero to two idle cycles of random latency. Read words come from a precomputed per-run script of busy, failing, racing and settled phases. The bench derives the expected read count and outcome by walking that script under the requirements.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEED  = 3'd1,
        ST_POLL  = 3'd2,
        ST_CHK_A = 3'd3,
        ST_CHK_B = 3'd4,
        ST_RESET = 3'd5,
        ST_OK    = 3'd6,
        ST_FAIL  = 3'd7
    } fdp_state_e;
endpackage

// File: rtl/fdp_status_eval.sv
module fdp_status_eval #(
    parameter int DW       = 8,
    parameter int TGL_BIT  = 6,
    parameter int POLL_BIT = 7,
    parameter int FAIL_BIT = 5
) (
    input  logic [DW-1:0] word_i,
    input  logic          prev_tgl_i,
    input  logic          dpoll_i,
    input  logic          target_i,
    output logic          cur_tgl_o,
    output logic          finished_o,
    output logic          fault_o
);
    always_comb begin
        cur_tgl_o = word_i[TGL_BIT];
        fault_o   = word_i[FAIL_BIT];
        if (dpoll_i) begin
            finished_o = (word_i[POLL_BIT] == target_i);
        end else begin
            finished_o = (word_i[TGL_BIT] == prev_tgl_i);
        end
    end
endmodule

// File: rtl/fdp_poll_budget.sv
module fdp_poll_budget #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
    parameter int          DW        = 8,
    parameter int          MAX_POLLS = 64,
    parameter int          TGL_BIT   = 6,
    parameter int          POLL_BIT  = 7,
    parameter int          FAIL_BIT  = 5,
    parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          use_dpoll_i,
    input  logic          erase_i,
    input  logic          exp_bit_i,
    output logic          rd_req_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    input  logic          wr_ack_i,
    output logic [DW-1:0] wr_data_o,
    output logic          done_o,
    output logic          err_o
);
    import fdp_pkg::*;

    fdp_state_e state_q, state_d;
    logic       dpoll_q;
    logic       target_q;
    logic       prev_tgl_q;
    logic       conf_tgl_q;

    logic       cur_tgl;
    logic       finished;
    logic       fault;
    logic       budget_last;
    logic       poll_phase;

    fdp_status_eval #(
        .DW       (DW),
        .TGL_BIT  (TGL_BIT),
        .POLL_BIT (POLL_BIT),
        .FAIL_BIT (FAIL_BIT)
    ) u_eval (
        .word_i     (rd_data_i),
        .prev_tgl_i (prev_tgl_q),
        .dpoll_i    (dpoll_q),
        .target_i   (target_q),
        .cur_tgl_o  (cur_tgl),
        .finished_o (finished),
        .fault_o    (fault)
    );

    assign poll_phase = (state_q == ST_SEED) || (state_q == ST_POLL);

    fdp_poll_budget #(
        .MAX_POLLS (MAX_POLLS)
    ) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_IDLE),
        .tick_i  (rd_ack_i && poll_phase),
        .last_o  (budget_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured run context and toggle history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dpoll_q    <= 1'b0;
            target_q   <= 1'b0;
            prev_tgl_q <= 1'b0;
            conf_tgl_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                dpoll_q  <= use_dpoll_i;
                target_q <= erase_i ? 1'b1 : exp_bit_i;
            end
            if (rd_ack_i && poll_phase) begin
                prev_tgl_q <= cur_tgl;
            end
            if (rd_ack_i && state_q == ST_CHK_A) begin
                conf_tgl_q <= cur_tgl;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = use_dpoll_i ? ST_POLL : ST_SEED;
                end
            end
            ST_SEED: begin
                if (rd_ack_i) begin
                    state_d = ST_POLL;
                end
            end
            ST_POLL: begin
                if (rd_ack_i) begin
                    if (finished) begin
                        state_d = ST_OK;
                    end else if (fault) begin
                        state_d = ST_CHK_A;
                    end else if (budget_last) begin
                        state_d = ST_RESET;
                    end
                end
            end
            ST_CHK_A: begin
                if (rd_ack_i) begin
                    state_d = ST_CHK_B;
                end
            end
            ST_CHK_B: begin
                if (rd_ack_i) begin
                    state_d = (cur_tgl == conf_tgl_q) ? ST_OK : ST_RESET;
                end
            end
            ST_RESET: begin
                if (wr_ack_i) begin
                    state_d = ST_FAIL;
                end
            end
            ST_OK:   state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req_o  = 1'b0;
        wr_req_o  = 1'b0;
        wr_data_o = RST_CMD;
        done_o    = 1'b0;
        err_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SEED:  rd_req_o = 1'b1;
            ST_POLL:  rd_req_o = 1'b1;
            ST_CHK_A: rd_req_o = 1'b1;
            ST_CHK_B: rd_req_o = 1'b1;
            ST_RESET: wr_req_o = 1'b1;
            ST_OK:    done_o   = 1'b1;
            ST_FAIL:  err_o    = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req_o,
    input logic          rd_ack_i,
    input logic          wr_req_o,
    input logic          wr_ack_i,
    input logic [DW-1:0] wr_data_o,
    input logic          done_o,
    input logic          err_o
);
    p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> wr_req_o);

    p_wr_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_data_o == RST_CMD));

    p_err_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_req_o && wr_ack_i));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    p_quiet_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> (!rd_req_o && !wr_req_o));
endmodule

bind flash_done_poller fdp_checker #(
    .DW      (DW),
    .RST_CMD (RST_CMD)
) u_fdp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .wr_req_o  (wr_req_o),
    .wr_ack_i  (wr_ack_i),
    .wr_data_o (wr_data_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/tb_flash_done_poller.sv
`timescale 1ns/1ps
module tb_flash_done_poller;
    localparam int DW   = 8;
    localparam int MAXP = 20;
    localparam int NW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          use_dpoll_i = 1'b0;
    logic          erase_i = 1'b0;
    logic          exp_bit_i = 1'b0;
    logic          rd_req_o;
    logic          rd_ack_i;
    logic [DW-1:0] rd_data_i;
    logic          wr_req_o;
    logic          wr_ack_i;
    logic [DW-1:0] wr_data_o;
    logic          done_o;
    logic          err_o;

    always #2 clk = ~clk;

    flash_done_poller #(.DW(DW), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_dpoll_i(use_dpoll_i),
        .erase_i(erase_i), .exp_bit_i(exp_bit_i), .rd_req_o(rd_req_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .wr_req_o(wr_req_o),
        .wr_ack_i(wr_ack_i), .wr_data_o(wr_data_o), .done_o(done_o), .err_o(err_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] words [NW];
    int rd_idx = 0;
    int n_wr = 0;
    int wr_seen = 0;
    int n_done = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Flash responder and output monitor, acting at falling edges
    initial begin
        int rlat = 0;
        int wlat = 0;
        rd_ack_i = 1'b0;
        rd_data_i = '0;
        wr_ack_i = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
                rd_idx++;
            end else if (rd_req_o) begin
                if (rlat == 0) begin
                    rd_ack_i = 1'b1;
                    rd_data_i = words[rd_idx % NW];
                    rlat = $urandom_range(0, 2);
                end else begin
                    rlat--;
                end
            end
            if (wr_ack_i) begin
                wr_ack_i = 1'b0;
                n_wr++;
            end else if (wr_req_o) begin
                if (wlat == 0) begin
                    wr_ack_i = 1'b1;
                    wr_seen = int'(wr_data_o);
                    wlat = $urandom_range(0, 2);
                end else begin
                    wlat--;
                end
            end
            if (done_o) n_done++;
            if (err_o) n_err++;
        end
    end

    // Script of read words: busy for reads below nb, fault bit from read f on
    task automatic build(input bit tgt, input int nb, input int f);
        for (int i = 0; i < NW; i++) begin
            logic [DW-1:0] w;
            bit busy;
            bit frozen;
            w = DW'($urandom);
            busy = (i < nb);
            frozen = (nb == 0) ? 1'b0 : 1'(((nb - 1) & 1));
            w[6] = busy ? 1'(i & 1) : frozen;
            w[7] = busy ? ~tgt : tgt;
            if (busy) w[5] = (f >= 0 && i >= f);
            words[i] = w;
        end
    endtask

    // Expected read count and outcome derived from the requirements
    function automatic void model(input bit dp, input bit tgt,
                                  output int nreads, output bit ok);
        int cnt = 0;
        bit prev = 1'b0;
        int i0 = 0;
        nreads = 0;
        ok = 1'b0;
        if (!dp) begin
            prev = words[0][6];
            cnt = 1;
            i0 = 1;
        end
        for (int i = i0; i < NW - 2; i++) begin
            bit fin;
            cnt++;
            fin = dp ? (words[i][7] == tgt) : (words[i][6] == prev);
            if (fin) begin
                nreads = i + 1; ok = 1'b1; return;
            end
            if (words[i][5]) begin
                nreads = i + 3; ok = (words[i+1][6] == words[i+2][6]); return;
            end
            if (cnt == MAXP) begin
                nreads = i + 1; ok = 1'b0; return;
            end
            prev = words[i][6];
        end
    endfunction

    task automatic run(input string req, input bit dp, input bit er, input bit eb,
                       input int nb, input int f, input bit restart);
        int exp_n;
        bit exp_ok;
        bit tgt;
        int waited = 0;
        tgt = er ? 1'b1 : eb;
        build(tgt, nb, f);
        model(dp, tgt, exp_n, exp_ok);
        @(posedge clk); #1;
        rd_idx = 0; n_wr = 0; wr_seen = 0; n_done = 0; n_err = 0;
        use_dpoll_i = dp; erase_i = er; exp_bit_i = eb; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (restart) begin
            repeat (3) @(posedge clk);
            #1;
            use_dpoll_i = ~dp; erase_i = ~er; exp_bit_i = ~eb; start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        while (n_done + n_err == 0 && waited < 400) begin
            @(posedge clk); #1;
            waited++;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(n_done == int'(exp_ok) && n_err == int'(!exp_ok), req, "done pulses",
            n_done, int'(exp_ok));
        chk(n_done + n_err == 1, "R8", "completion pulse count", n_done + n_err, 1);
        chk(rd_idx == exp_n, (restart ? "R9" : "R10"), "reads issued", rd_idx, exp_n);
        chk(n_wr == int'(!exp_ok), (exp_ok ? req : "R6"), "reset writes",
            n_wr, int'(!exp_ok));
        if (!exp_ok) chk(wr_seen == 'hF0, "R6", "reset command word", wr_seen, 'hF0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        chk(!rd_req_o, "R1", "rd_req in reset", int'(rd_req_o), 0);
        chk(!wr_req_o, "R1", "wr_req in reset", int'(wr_req_o), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!done_o && !err_o, "R1", "pulses after reset", int'(done_o | err_o), 0);
        chk(!rd_req_o && !wr_req_o, "R1", "requests after reset",
            int'(rd_req_o | wr_req_o), 0);

        run("R2", 0, 0, 0, 5, -1, 0);
        run("R2", 0, 0, 1, 0, -1, 0);
        run("R11", 0, 1, 0, 1, -1, 0);
        run("R11", 0, 1, 0, 2, -1, 0);
        run("R3", 1, 0, 1, 4, -1, 0);
        run("R3", 1, 0, 0, 3, -1, 0);
        run("R4", 1, 1, 0, 6, -1, 0);
        run("R4", 1, 1, 1, 0, -1, 0);
        run("R6", 0, 0, 0, 99, 3, 0);
        run("R5", 0, 0, 0, 4, 3, 0);
        run("R5", 0, 1, 0, 5, 3, 0);
        run("R6", 1, 0, 1, 99, 2, 0);
        run("R5", 1, 1, 0, 3, 2, 0);
        run("R7", 0, 0, 0, 99, -1, 0);
        run("R7", 1, 0, 1, 99, -1, 0);
        run("R9", 0, 0, 0, 8, -1, 1);
        run("R9", 1, 1, 0, 9, -1, 1);

        for (int k = 0; k < 40; k++) begin
            bit dp;
            bit er;
            bit eb;
            int nb;
            int f;
            dp = 1'($urandom);
            er = 1'($urandom);
            eb = 1'($urandom);
            nb = ($urandom_range(0, 5) == 0) ? 99 : $urandom_range(0, 12);
            f = -1;
            if ($urandom_range(0, 2) == 0) begin
                f = $urandom_range(1, 10);
                if (nb != 99 && $urandom_range(0, 1) == 0) nb = f + $urandom_range(1, 2);
            end
            run("R10", dp, er, eb, nb, f, 1'($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule